// File: doc/BRIEF.md
# Stepper Microstep Sequence Indexer

The indexer turns a train of step pulses into current set-points for the two windings of a bipolar stepper motor. It keeps one electrical angle as a 5-bit index, where one unit is 11.25 degrees and 32 units make a full electrical turn. Each qualified rising edge on the step input moves that index forward or backward by a stride that the excitation mode selects. From the index the block forms a signed set-point for each winding. The magnitude is given in tenths of a percent, where 1000 means full scale, and a separate sign bit marks negative current.

Five excitation modes share one quarter-wave sine table: full-step (4 states), half-step (8 states), 1-2 phase (8 states), 16-state and 32-state microstepping. Phase B trails phase A by 90 degrees when stepping forward and leads it when stepping backward. A synchronous home request, or reset, returns the index to the mode's default angle. A home flag marks the state from which the excitation mode can be changed with the least disturbance. The output-off input forces zero current, but steps are still counted while it is high.

Top module: `stepper_indexer`

## Requirements
- R1: The mode select decodes as follows. If `sel[2]`=1, the mode is 32-state with a stride of 1 unit. Otherwise `sel[1:0]` picks the mode: 00 is full-step (stride 8), 01 is half-step (stride 4), 10 is 1-2 phase (stride 4) and 11 is 16-state (stride 2).
- R2: `step_in` passes through a two-flop synchronizer and is then edge-detected. Each low-to-high transition moves the index exactly once, on the third rising clock edge after `step_in` rises. `dir_in` travels through the same synchronizer.
- R3: Outside full-step and half-step, `a_mag` is |sin(idx*11.25 deg)| and `b_mag` is |cos(idx*11.25 deg)|, both in tenths of a percent, taken from the set {0,195,383,556,707,832,924,981,1000}. `a_neg` is set when sin is negative, and `b_neg` is set when -cos is negative. A zero magnitude never carries a set sign bit.
- R4: When `dir_in`=0 the index increases by the stride, so phase B lags phase A. When `dir_in`=1 the index decreases, so phase B leads. A reversal continues from the state it holds, so in 1-2 phase mode the states run 5,6,7 and then 6,5,4.
- R5: In half-step mode, any magnitude that would not be zero is driven at 1000. The diagonal states therefore have both phases at full scale.
- R6: In full-step mode, both magnitudes are 1000. The signs follow quadrant q=idx[4:3]: phase A is negative for q of 2 or 3, and phase B is negative for q of 0 or 3.
- R7: If `rst_n`=0 or `home_req`=1 at a clock edge, the index is loaded with 28 (-45 deg) in full-step mode and with 0 in every other mode. `home_req` takes priority over a step arriving on the same edge.
- R8: While `out_off`=1, both magnitudes and both sign bits are 0, and steps still move the index. When `out_off` returns to 0, the set-points resume from the advanced index.
- R9: `home_flag` is 1 exactly when the index equals the current mode's default: 28 in full-step, 0 otherwise. This is the state with phase B at -1000, and it does not depend on `out_off`.
- R10: A change of `sel` or `out_off` never moves the index. The set-points follow the new setting within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; loads the default index |
| step_in | input | 1 | Asynchronous step pulse; rising edge advances |
| dir_in | input | 1 | Direction: 0 forward, 1 reverse |
| sel | input | 3 | Excitation mode select |
| out_off | input | 1 | 1 forces zero current set-points |
| home_req | input | 1 | Synchronous request to return to the default angle |
| a_neg | output | 1 | Phase A sign, 1 = negative |
| a_mag | output | 10 | Phase A magnitude, tenths of a percent |
| b_neg | output | 1 | Phase B sign, 1 = negative |
| b_mag | output | 10 | Phase B magnitude, tenths of a percent |
| home_flag | output | 1 | Index at the mode's default state |

## Verification
A step shows at the set-point outputs after the third rising clock edge that follows the rise of `step_in`. A home request or reset takes effect on the first edge. Changes of `sel` or `out_off` are combinational and appear within the same cycle. The bench drives inputs on falling edges and samples at least four cycles after each step pulse, which is past the three-edge latency. A directed case samples just after the second and the third edge to pin that latency exactly, and a home request is placed on the same edge as a step to confirm that it wins.

// File: rtl/stepidx_pkg.sv
package stepidx_pkg;
  localparam int IDX_W     = 5;
  localparam int POS_COUNT = 1 << IDX_W;
  localparam int QTR       = POS_COUNT / 4;
  localparam int MAG_W     = 10;
  localparam logic [MAG_W-1:0] FULL_MAG = MAG_W'(1000);
  localparam int FULL_HOME = POS_COUNT - QTR / 2;

  typedef logic [IDX_W-1:0] idx_t;

  typedef enum logic [2:0] {
    EXC_FULL, EXC_HALF, EXC_ONE_TWO, EXC_SIXTEEN, EXC_THIRTY_TWO
  } exc_e;

  typedef struct packed {
    logic             neg;
    logic [MAG_W-1:0] mag;
  } setpt_t;

  function automatic exc_e decode_exc(input logic [2:0] s);
    if (s[2]) return EXC_THIRTY_TWO;
    case (s[1:0])
      2'b00:   return EXC_FULL;
      2'b01:   return EXC_HALF;
      2'b10:   return EXC_ONE_TWO;
      default: return EXC_SIXTEEN;
    endcase
  endfunction

  function automatic idx_t exc_stride(input exc_e e);
    case (e)
      EXC_FULL:             return idx_t'(QTR);
      EXC_HALF, EXC_ONE_TWO: return idx_t'(QTR / 2);
      EXC_SIXTEEN:          return idx_t'(QTR / 4);
      default:              return idx_t'(1);
    endcase
  endfunction

  function automatic idx_t exc_default(input exc_e e);
    return (e == EXC_FULL) ? idx_t'(FULL_HOME) : idx_t'(0);
  endfunction

  // quarter-wave magnitude in tenths of a percent, k in 0..QTR
  function automatic logic [MAG_W-1:0] quarter_sine(input int k);
    case (k)
      0:       return MAG_W'(0);
      1:       return MAG_W'(195);
      2:       return MAG_W'(383);
      3:       return MAG_W'(556);
      4:       return MAG_W'(707);
      5:       return MAG_W'(832);
      6:       return MAG_W'(924);
      7:       return MAG_W'(981);
      default: return FULL_MAG;
    endcase
  endfunction

  // signed sine set-point at an index, shaped by the excitation mode
  function automatic setpt_t phase_setpt(input idx_t pos, input exc_e e);
    setpt_t r;
    logic [1:0] quad;
    int sub;
    int k;
    quad = pos[IDX_W-1 -: 2];
    sub  = int'(pos[IDX_W-3:0]);
    if (e == EXC_FULL) begin
      r.mag = FULL_MAG;
      r.neg = quad[1];
    end else begin
      k     = quad[0] ? (QTR - sub) : sub;
      r.mag = quarter_sine(k);
      if (e == EXC_HALF && r.mag != '0) r.mag = FULL_MAG;
      r.neg = quad[1] && (r.mag != '0);
    end
    return r;
  endfunction
endpackage

// File: rtl/stepidx_sync.sv
module stepidx_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/stepidx_pos.sv
module stepidx_pos
  import stepidx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic home_req,
  input  logic adv,
  input  logic rev,
  input  exc_e exc,
  output idx_t pos
);
  idx_t stride;
  assign stride = exc_stride(exc);

  always_ff @(posedge clk) begin
    if (!rst_n || home_req)
      pos <= exc_default(exc);
    else if (adv)
      pos <= rev ? idx_t'(pos - stride) : idx_t'(pos + stride);
  end
endmodule

// File: rtl/stepidx_phase.sv
module stepidx_phase
  import stepidx_pkg::*;
#(
  parameter int OFFSET = 0
) (
  input  idx_t             pos,
  input  exc_e             exc,
  input  logic             off,
  output logic             neg,
  output logic [MAG_W-1:0] mag
);
  setpt_t sp;
  assign sp  = phase_setpt(idx_t'(pos - idx_t'(OFFSET)), exc);
  assign neg = off ? 1'b0 : sp.neg;
  assign mag = off ? '0 : sp.mag;
endmodule

// File: rtl/stepper_indexer.sv
module stepper_indexer
  import stepidx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_in,
  input  logic             dir_in,
  input  logic [2:0]       sel,
  input  logic             out_off,
  input  logic             home_req,
  output logic             a_neg,
  output logic [MAG_W-1:0] a_mag,
  output logic             b_neg,
  output logic [MAG_W-1:0] b_mag,
  output logic             home_flag
);
  localparam int PHASES = 2;

  logic step_s, dir_s, step_last, step_rise;
  exc_e exc;
  idx_t pos;
  logic             ph_neg [PHASES];
  logic [MAG_W-1:0] ph_mag [PHASES];

  stepidx_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({step_in, dir_in}), .q({step_s, dir_s})
  );

  always_ff @(posedge clk) begin
    if (!rst_n) step_last <= 1'b0;
    else        step_last <= step_s;
  end

  assign step_rise = step_s && !step_last;
  assign exc       = decode_exc(sel);

  stepidx_pos u_pos (
    .clk(clk), .rst_n(rst_n), .home_req(home_req),
    .adv(step_rise), .rev(dir_s), .exc(exc), .pos(pos)
  );

  // phase A at the index, phase B a quarter turn behind it
  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    stepidx_phase #(.OFFSET(p * QTR)) u_ph (
      .pos(pos), .exc(exc), .off(out_off),
      .neg(ph_neg[p]), .mag(ph_mag[p])
    );
  end

  assign a_neg     = ph_neg[0];
  assign a_mag     = ph_mag[0];
  assign b_neg     = ph_neg[1];
  assign b_mag     = ph_mag[1];
  assign home_flag = (pos == exc_default(exc));
endmodule

// File: rtl/stepper_indexer_chk.sv
module stepper_indexer_chk
  import stepidx_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             home_req,
  input logic             step_rise,
  input logic             dir_s,
  input logic [2:0]       sel,
  input idx_t             pos,
  input logic             out_off,
  input logic             a_neg,
  input logic [MAG_W-1:0] a_mag,
  input logic             b_neg,
  input logic [MAG_W-1:0] b_mag,
  input logic             home_flag
);
  function automatic idx_t units_of(input logic [2:0] s);
    if (s[2]) return idx_t'(1);
    if (s[1:0] == 2'b00) return idx_t'(8);
    if (s[1:0] == 2'b11) return idx_t'(2);
    return idx_t'(4);
  endfunction

  // R2
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_rise && !home_req) |=> pos == $past(pos));

  // R2
  single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_rise |=> !step_rise);

  // R4
  fwd_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_rise && !dir_s && !home_req) |=> pos == idx_t'($past(pos) + units_of($past(sel))));

  // R4
  rev_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_rise && dir_s && !home_req) |=> pos == idx_t'($past(pos) - units_of($past(sel))));

  // R7
  home_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    home_req |=> pos == (($past(sel) == 3'b000) ? idx_t'(FULL_HOME) : idx_t'(0)));

  // R8
  off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_off |-> (a_mag == '0 && b_mag == '0 && !a_neg && !b_neg));

  // R9
  home_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (home_flag && !out_off) |-> (b_neg && b_mag == FULL_MAG));

  // R3
  sign_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((a_mag == '0) |-> !a_neg) and ((b_mag == '0) |-> !b_neg));

  // R3
  mag_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_mag <= FULL_MAG && b_mag <= FULL_MAG);
endmodule

bind stepper_indexer stepper_indexer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .home_req(home_req), .step_rise(step_rise),
  .dir_s(dir_s), .sel(sel), .pos(pos), .out_off(out_off),
  .a_neg(a_neg), .a_mag(a_mag), .b_neg(b_neg), .b_mag(b_mag),
  .home_flag(home_flag)
);

// File: tb/stepper_indexer_test.sv
`timescale 1ns/1ps
module stepper_indexer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       step_in = 1'b0;
  logic       dir_in = 1'b0;
  logic [2:0] sel = 3'b100;
  logic       out_off = 1'b0;
  logic       home_req = 1'b0;
  logic       a_neg, b_neg, home_flag;
  logic [9:0] a_mag, b_mag;

  int  nchk = 0;
  int  nerr = 0;
  int  pos_m = 0;
  bit  done = 0;

  always #4 clk = ~clk;

  stepper_indexer uut (
    .clk(clk), .rst_n(rst_n), .step_in(step_in), .dir_in(dir_in), .sel(sel),
    .out_off(out_off), .home_req(home_req), .a_neg(a_neg), .a_mag(a_mag),
    .b_neg(b_neg), .b_mag(b_mag), .home_flag(home_flag)
  );

  // mode number: 0 full, 1 half, 2 one-two, 3 sixteen, 4 thirty-two (R1)
  function automatic int md_of(input logic [2:0] s);
    return s[2] ? 4 : int'(s[1:0]);
  endfunction

  function automatic int units(input int md);
    case (md)
      0: return 8;
      1, 2: return 4;
      3: return 2;
      default: return 1;
    endcase
  endfunction

  // signed set-point from trigonometry, tenths of a percent
  function automatic int exp_val(input int p, input int md, input bit phb);
    real ang, x;
    int m;
    if (md == 0) ang = (p / 8) * 90.0 + 45.0;
    else         ang = p * 11.25;
    ang = ang * 3.14159265358979 / 180.0;
    x = phb ? -$cos(ang) : $sin(ang);
    m = int'((x < 0.0 ? -x : x) * 1000.0);
    if (m == 831) m = 832;  // the set-point list rounds this entry up
    if (md == 0 || (md == 1 && m != 0)) m = 1000;
    return (x < 0.0 && m != 0) ? -m : m;
  endfunction

  task automatic check_eq(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d (pos %0d sel %b)", tag, act, exp, pos_m, sel);
    end
  endtask

  task automatic check_all(input string tag);
    int md, ea, eb;
    md = md_of(sel);
    ea = out_off ? 0 : exp_val(pos_m, md, 1'b0);
    eb = out_off ? 0 : exp_val(pos_m, md, 1'b1);
    check_eq({tag, " phase A"}, a_neg ? -int'(a_mag) : int'(a_mag), ea);
    check_eq({tag, " phase B"}, b_neg ? -int'(b_mag) : int'(b_mag), eb);
    check_eq({tag, " R9 home flag"}, int'(home_flag), int'(md == 0 ? pos_m == 28 : pos_m == 0));
  endtask

  task automatic model_step(input bit d);
    int u;
    u = units(md_of(sel));
    pos_m = (((pos_m + (d ? -u : u)) % 32) + 32) % 32;
  endtask

  task automatic step_pulse(input bit d);
    @(negedge clk) dir_in = d;
    repeat (2) @(negedge clk);
    step_in = 1'b1;
    repeat (4) @(negedge clk);
    step_in = 1'b0;
    repeat (4) @(negedge clk);
    model_step(d);
  endtask

  task automatic pulse_home();
    @(negedge clk) home_req = 1'b1;
    @(negedge clk) home_req = 1'b0;
    pos_m = (md_of(sel) == 0) ? 28 : 0;
  endtask

  task automatic set_mode(input logic [2:0] s);
    @(negedge clk) sel = s;
    #1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    pos_m = 0;
    @(negedge clk);
    check_all("R7 reset state 32-step");

    // R3 R4: a full forward turn in 32-step mode
    for (int i = 0; i < 32; i++) begin
      step_pulse(1'b0);
      check_all("R3 R4 forward sweep");
    end
    // R4: reverse turn
    for (int i = 0; i < 8; i++) begin
      step_pulse(1'b1);
      check_all("R4 reverse sweep");
    end

    // R1 R4: 1-2 phase reversal holds the state
    set_mode(3'b010);
    pulse_home();
    check_all("R7 home 1-2");
    for (int i = 0; i < 3; i++) begin step_pulse(1'b0); check_all("R4 1-2 fwd"); end
    for (int i = 0; i < 3; i++) begin step_pulse(1'b1); check_all("R4 1-2 back"); end
    check_eq("R4 1-2 returned to start", pos_m, 0);

    // R5: half-step diagonals at full scale
    set_mode(3'b001);
    for (int i = 0; i < 8; i++) begin step_pulse(1'b0); check_all("R5 half-step"); end

    // R6 R7: full-step default and sequence
    set_mode(3'b000);
    pulse_home();
    check_all("R7 R6 full-step default -45");
    for (int i = 0; i < 5; i++) begin step_pulse(1'b0); check_all("R6 full-step fwd"); end
    step_pulse(1'b1);
    check_all("R6 full-step rev");

    // R1: 16-state and codes with sel[2] set
    set_mode(3'b011);
    pulse_home();
    for (int i = 0; i < 4; i++) begin step_pulse(1'b0); check_all("R1 16-state"); end
    set_mode(3'b111);
    step_pulse(1'b0);
    check_all("R1 sel 111 is 32-state");

    // R10: mode change keeps index
    set_mode(3'b100);
    pulse_home();
    for (int i = 0; i < 8; i++) step_pulse(1'b0);
    check_all("R10 at quarter turn");
    set_mode(3'b011); check_all("R10 switch to 16");
    set_mode(3'b001); check_all("R10 switch to half");
    set_mode(3'b000); check_all("R10 switch to full");
    set_mode(3'b100); check_all("R10 back to 32");

    // R8: output off still counts steps
    @(negedge clk) out_off = 1'b1;
    #1;
    check_all("R8 off forces zero");
    for (int i = 0; i < 3; i++) begin step_pulse(1'b0); check_all("R8 off while stepping"); end
    @(negedge clk) out_off = 1'b0;
    #1;
    check_all("R8 resume from advanced index");
    check_eq("R8 index advanced", pos_m, 11);

    // R2: exact latency, three edges after step_in rises
    pulse_home();
    @(negedge clk) dir_in = 1'b0;
    repeat (2) @(negedge clk);
    @(posedge clk); #1 step_in = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check_all("R2 unchanged after two edges");
    @(posedge clk); #1;
    model_step(1'b0);
    check_all("R2 moved on third edge");
    repeat (4) @(negedge clk);
    step_in = 1'b0;
    repeat (4) @(negedge clk);
    check_all("R2 one move per pulse");

    // R7: home request wins over a step on the same edge
    @(posedge clk); #1 step_in = 1'b1;
    repeat (2) @(posedge clk);
    #1 home_req = 1'b1;
    @(posedge clk); #1 home_req = 1'b0;
    pos_m = 0;
    check_all("R7 home beats step");
    repeat (4) @(negedge clk);
    step_in = 1'b0;
    repeat (4) @(negedge clk);
    check_all("R7 after priority case");

    // R1-R10 mixed random stimulus
    for (int i = 0; i < 400; i++) begin
      int r;
      r = int'($urandom % 16);
      if (r == 0) begin
        pulse_home();
      end else if (r < 3) begin
        set_mode(3'($urandom));
      end else if (r == 3) begin
        @(negedge clk) out_off = ~out_off;
        #1;
      end else begin
        step_pulse(1'($urandom));
      end
      check_all("random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule